// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, once per frame, whether the frame should be kept, judging only by its 48-bit destination address. The address arrives as six bytes, first byte first. Each byte comes with a valid strobe, and a start-of-frame flag marks the first byte. Gaps between bytes are allowed. Shortly after the sixth byte, the block raises a one-cycle decision pulse. The pulse carries an accept flag and a code that tells which rule matched.

Four rules can accept a frame:
- A promiscuous mode accepts every frame.
- The all-ones broadcast address is always accepted.
- An exact match against a programmable station address is accepted.
- A group address is accepted when its entry in a 512-entry multicast hash table is set.

The hash index comes from a CRC-32 over the address bytes. Software programs the table one entry per write, through a control word that carries an index and a value. It can accept all multicast traffic by enabling all 512 entries.

Configuration is a simple write port with a two-bit register select. There is no read-back.

Top module: `rx_da_filter`

## Requirements
- R1: The station address is written in two parts. Select 0 writes address bytes 0..3, with byte 0 in bits [7:0] and byte 3 in bits [31:24]. Select 1 writes byte 4 in bits [7:0] and byte 5 in bits [15:8]. A frame whose address equals the station address gets kind 1 (station).
- R2: The hash index of an address is computed in four steps. (a) Run a reflected CRC-32 with polynomial 0xEDB88320 over the six bytes, least significant bit first, starting from 0xFFFFFFFF, with no final inversion. (b) Bit-reverse the 32-bit result. (c) Take bits [31:23] of the reversed value. (d) Those 9 bits are the index.
- R3: A write with select 2 changes exactly one table entry. Bits [8:0] of the write data give the entry index, and bit 9 gives the new value (1 = enable, 0 = disable). All other entries keep their values.
- R4: An address is a group address when bit 0 of byte 0 is 1. A group address that is neither broadcast nor the station address gets kind 3 (hash hit) when its table entry is 1, and kind 0 (reject) when the entry is 0.
- R5: A unicast address (bit 0 of byte 0 is 0) never matches through the hash table, even when its hash entry is enabled.
- R6: The address FF:FF:FF:FF:FF:FF gets kind 2 (broadcast), whatever the table holds.
- R7: A write with select 3 sets the promiscuous bit from bit 4 of the write data. While that bit is 1, every frame gets kind 4 (promiscuous).
- R8: `dec_vld` is high for exactly one cycle per complete address. It rises on the clock edge that follows the edge that samples the sixth byte. Idle cycles between the bytes are allowed.
- R9: Starting a new address:
  - A byte flagged as start of frame always restarts collection, even in the middle of an address.
  - A valid byte that arrives when no address is being collected is ignored.
- R10: After reset, the table, the station address and the promiscuous bit are all zero, and `dec_vld` is low.
- R11: When more than one rule applies, the priority from highest to lowest is: promiscuous, broadcast, station, hash hit.
- R12: On a decision, `dec_accept` is 1 exactly when the kind is not 0. The kind codes are: 0 reject, 1 station, 2 broadcast, 3 hash hit, 4 promiscuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 station low, 1 station high, 2 hash control, 3 mode |
| cfg_wdata | input | 32 | Configuration write data |
| da_vld | input | 1 | Address byte valid |
| da_sof | input | 1 | Marks byte 0 of a destination address |
| da_byte | input | 8 | Address byte |
| dec_vld | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_kind | output | 3 | Match kind code |

## Verification
The bench loads striped table patterns and sweeps a few hundred pseudo-random group addresses against them. It works out each hash index arithmetically, so any CRC seeding, bit-reversal or index-slice error shows up as wrong hits. Further tests target specific faults:
- A unicast address whose hash entry is enabled: a design that skips the group-bit test accepts it.
- A station address equal to a hashed group address, and a station address of all ones: a design with the wrong priority reports the wrong kind.
- Sending the all-zero address right after reset: it must match the reset station value.
- Single-entry clears after enabling all entries: a design that writes a whole word instead of one bit loses its neighbours.
- Interrupted addresses, stray bytes and inter-byte gaps: a design with a miscounted position misses or duplicates the decision pulse.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

   typedef enum logic [2:0] {
      KIND_REJECT  = 3'd0,
      KIND_STATION = 3'd1,
      KIND_BCAST   = 3'd2,
      KIND_HASH    = 3'd3,
      KIND_PROMISC = 3'd4
   } rdf_kind_e;

   localparam logic [1:0] SEL_STA_LO = 2'd0;
   localparam logic [1:0] SEL_STA_HI = 2'd1;
   localparam logic [1:0] SEL_HASH   = 2'd2;
   localparam logic [1:0] SEL_MODE   = 2'd3;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

endpackage

// File: rtl/rdf_capture.sv
module rdf_capture #(
   parameter int ADDR_BYTES = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic                    in_sof,
   input  logic [7:0]              in_byte,
   output logic                    step,
   output logic                    restart,
   output logic [ADDR_BYTES*8-1:0] addr_q,
   output logic                    done_q
);
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam int LAST  = ADDR_BYTES - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pos;
   logic             open_q;
   logic             take;
   logic             last_byte;
   logic [7:0]       byte_q [ADDR_BYTES];

   assign take      = in_vld && (in_sof || open_q);
   assign restart   = in_vld && in_sof;
   assign step      = take;
   assign pos       = in_sof ? '0 : cnt_q;
   assign last_byte = (pos == CNT_W'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         open_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= take && last_byte;
         if (take) begin
            cnt_q  <= pos + CNT_W'(1);
            open_q <= !last_byte;
         end
      end
   end

   for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q[i] <= '0;
         else if (take && (pos == CNT_W'(i)))
            byte_q[i] <= in_byte;
      end
      assign addr_q[i*8 +: 8] = byte_q[i];
   end

   // R9
   sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == CNT_W'(1)));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/rdf_crc_hash.sv
module rdf_crc_hash import rdf_pkg::*; #(
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   input  logic [7:0]       data_byte,
   output logic [IDX_W-1:0] idx
);
   logic [31:0] crc_q;
   logic [31:0] base;
   logic [31:0] chain [9];

   assign base     = restart ? CRC_SEED : crc_q;
   assign chain[0] = base ^ {24'd0, data_byte};

   for (genvar k = 0; k < 8; k++) begin : g_bit
      assign chain[k+1] = chain[k][0] ? ((chain[k] >> 1) ^ CRC_POLY_REFL)
                                      : (chain[k] >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= CRC_SEED;
      else if (step)
         crc_q <= chain[8];
   end

   // Top bits of the bit-reversed CRC are the low CRC bits in reverse order.
   for (genvar k = 0; k < IDX_W; k++) begin : g_idx
      assign idx[IDX_W-1-k] = crc_q[k];
   end

   // R2
   crc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && restart && (data_byte == 8'h00)) |=> (crc_q != CRC_SEED));

endmodule

// File: rtl/rdf_hash_table.sv
module rdf_hash_table #(
   parameter int IDX_W  = 9,
   parameter int WORD_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_val,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_bit
);
   localparam int BIT_W   = $clog2(WORD_W);
   localparam int WSEL_W  = IDX_W - BIT_W;
   localparam int N_WORDS = (1 << IDX_W) / WORD_W;

   logic [WORD_W-1:0] tbl_q [N_WORDS];
   logic [WSEL_W-1:0] wr_word;
   logic [BIT_W-1:0]  wr_bit;

   assign wr_word = wr_idx[IDX_W-1:BIT_W];
   assign wr_bit  = wr_idx[BIT_W-1:0];

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tbl_q[w] <= '0;
         else if (wr_en && (wr_word == WSEL_W'(w)))
            tbl_q[w][wr_bit] <= wr_val;
      end
   end

   assign rd_bit = tbl_q[rd_idx[IDX_W-1:BIT_W]][rd_idx[BIT_W-1:0]];

   // R3
   tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (tbl_q[$past(wr_word)][$past(wr_bit)] == $past(wr_val)));

endmodule

// File: rtl/rdf_decide.sv
module rdf_decide import rdf_pkg::*; #(
   parameter int ADDR_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] station,
   input  logic              promisc,
   input  logic              hash_bit,
   output logic              dec_vld,
   output logic              dec_accept,
   output logic [2:0]        dec_kind
);
   rdf_kind_e kind_d;
   rdf_kind_e kind_q;
   logic      is_group;

   assign is_group = addr[0];

   always_comb begin
      if (promisc)
         kind_d = KIND_PROMISC;
      else if (&addr)
         kind_d = KIND_BCAST;
      else if (addr == station)
         kind_d = KIND_STATION;
      else if (is_group && hash_bit)
         kind_d = KIND_HASH;
      else
         kind_d = KIND_REJECT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_vld    <= 1'b0;
         dec_accept <= 1'b0;
         kind_q     <= KIND_REJECT;
      end else begin
         dec_vld    <= eval;
         dec_accept <= eval && (kind_d != KIND_REJECT);
         kind_q     <= eval ? kind_d : KIND_REJECT;
      end
   end

   assign dec_kind = kind_q;

   // R7
   promisc_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && promisc) |=> (dec_vld && (dec_kind == KIND_PROMISC)));

   // R5
   unicast_nohash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !addr[0]) |=> (dec_kind != KIND_HASH));

   // R6
   bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && (&addr)) |=> dec_accept);

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter import rdf_pkg::*; #(
   parameter int ADDR_BYTES  = 6,
   parameter int IDX_W       = 9,
   parameter int WORD_W      = 32,
   parameter int CFG_W       = 32,
   parameter int PROMISC_BIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             da_vld,
   input  logic             da_sof,
   input  logic [7:0]       da_byte,
   output logic             dec_vld,
   output logic             dec_accept,
   output logic [2:0]       dec_kind
);
   localparam int ADDR_W = ADDR_BYTES * 8;
   localparam int HI_W   = ADDR_W - CFG_W;

   if (ADDR_BYTES != 6) begin : g_bad_bytes
      $error("rx_da_filter: destination address must be six bytes");
   end
   if (((1 << IDX_W) % WORD_W) != 0) begin : g_bad_word
      $error("rx_da_filter: table size must be a multiple of the word width");
   end
   if ((IDX_W + 1) > CFG_W) begin : g_bad_idx
      $error("rx_da_filter: hash control word too narrow");
   end
   if (PROMISC_BIT >= CFG_W) begin : g_bad_mode
      $error("rx_da_filter: promiscuous bit outside the data word");
   end

   logic [CFG_W-1:0]  sta_lo_q;
   logic [HI_W-1:0]   sta_hi_q;
   logic              promisc_q;
   logic [ADDR_W-1:0] station;
   logic              step;
   logic              restart;
   logic [ADDR_W-1:0] addr_q;
   logic              done;
   logic [IDX_W-1:0]  hash_idx;
   logic              hash_bit;
   logic              tbl_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sta_lo_q  <= '0;
         sta_hi_q  <= '0;
         promisc_q <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_STA_LO: sta_lo_q  <= cfg_wdata;
            SEL_STA_HI: sta_hi_q  <= cfg_wdata[HI_W-1:0];
            SEL_MODE:   promisc_q <= cfg_wdata[PROMISC_BIT];
            default:    ;
         endcase
      end
   end

   assign station = {sta_hi_q, sta_lo_q};
   assign tbl_we  = cfg_we && (cfg_sel == SEL_HASH);

   rdf_capture #(.ADDR_BYTES(ADDR_BYTES)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (da_vld),
      .in_sof  (da_sof),
      .in_byte (da_byte),
      .step    (step),
      .restart (restart),
      .addr_q  (addr_q),
      .done_q  (done)
   );

   rdf_crc_hash #(.IDX_W(IDX_W)) u_crc (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .restart   (restart),
      .data_byte (da_byte),
      .idx       (hash_idx)
   );

   rdf_hash_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_we),
      .wr_idx (cfg_wdata[IDX_W-1:0]),
      .wr_val (cfg_wdata[IDX_W]),
      .rd_idx (hash_idx),
      .rd_bit (hash_bit)
   );

   rdf_decide #(.ADDR_W(ADDR_W)) u_decide (
      .clk        (clk),
      .rst_n      (rst_n),
      .eval       (done),
      .addr       (addr_q),
      .station    (station),
      .promisc    (promisc_q),
      .hash_bit   (hash_bit),
      .dec_vld    (dec_vld),
      .dec_accept (dec_accept),
      .dec_kind   (dec_kind)
   );

   // R8
   dec_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> $past(done));

   // R12
   accept_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> (dec_accept == (dec_kind != KIND_REJECT)));

   // R11
   station_over_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !promisc_q && !(&addr_q) && (addr_q == station))
         |=> (dec_kind == KIND_STATION));

endmodule

// File: tb/rx_da_filter_tb.sv
module rx_da_filter_tb;
   localparam int NENT = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic        da_vld = 1'b0;
   logic        da_sof = 1'b0;
   logic [7:0]  da_byte = '0;
   logic        dec_vld;
   logic        dec_accept;
   logic [2:0]  dec_kind;

   int n_tests = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   bit          tbl_m [NENT];
   logic [47:0] sta_m = '0;
   bit          prom_m = 1'b0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #2 clk = ~clk;

   rx_da_filter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .da_vld(da_vld), .da_sof(da_sof),
      .da_byte(da_byte), .dec_vld(dec_vld), .dec_accept(dec_accept),
      .dec_kind(dec_kind)
   );

   function automatic logic [8:0] hidx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      logic [31:0] r;
      for (int b = 0; b < 6; b++) begin
         c = c ^ {24'd0, a[8*b +: 8]};
         for (int k = 0; k < 8; k++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      for (int k = 0; k < 32; k++) r[31-k] = c[k];
      return r[31:23];
   endfunction

   function automatic logic [2:0] model(input logic [47:0] a);
      if (prom_m) return 3'd4;
      if (a == 48'hFFFF_FFFF_FFFF) return 3'd2;
      if (a == sta_m) return 3'd1;
      if (a[0] && tbl_m[hidx(a)]) return 3'd3;
      return 3'd0;
   endfunction

   function automatic logic [47:0] next_addr();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      return rng[47:0];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_station(input logic [47:0] a);
      wr(2'd0, a[31:0]);
      wr(2'd1, {16'd0, a[47:32]});
      sta_m = a;
   endtask

   task automatic set_entry(input int i, input bit v);
      wr(2'd2, {22'd0, v, 9'(i)});
      tbl_m[i] = v;
   endtask

   task automatic set_prom(input bit v);
      wr(2'd3, {27'd0, v, 4'd0});
      prom_m = v;
   endtask

   // Sends one address and checks the decision pulse timing and kind.
   task automatic frame(input logic [47:0] a, input int gap, input string req);
      logic [2:0] exp = model(a);
      bit early, on, late;
      for (int i = 0; i < 6; i++) begin
         da_vld = 1'b1; da_sof = (i == 0); da_byte = a[8*i +: 8];
         @(posedge clk); @(negedge clk);
         da_vld = 1'b0; da_sof = 1'b0;
         if (i < 5) repeat (gap) begin @(posedge clk); @(negedge clk); end
      end
      early = dec_vld;
      @(posedge clk); @(negedge clk);
      on = dec_vld;
      check(dec_kind == exp, req, dec_kind, exp);
      check(dec_accept == (exp != 3'd0), "R12 accept", dec_accept, exp != 3'd0);
      @(posedge clk); @(negedge clk);
      late = dec_vld;
      check(!early && on && !late, "R8 pulse timing",
            {29'd0, early, on, late}, 3'b010);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [47:0] a, u, m1, m2;
      bit quiet;
      for (int i = 0; i < NENT; i++) tbl_m[i] = 1'b0;
      repeat (3) @(negedge clk);
      check(dec_vld == 1'b0, "R10 dec_vld low in reset", dec_vld, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(dec_vld == 1'b0, "R10 dec_vld low after reset", dec_vld, 0);

      // R10: zero station matches zero address; empty table rejects groups.
      frame(48'h0, 0, "R10 reset station");
      for (int n = 0; n < 20; n++) begin
         a = next_addr() | 48'h1;
         frame(a, 0, "R10 R4 empty table");
      end

      // R1 station programming and near-miss addresses
      set_station(48'h5A4B_3C2D_1E0E);
      frame(48'h5A4B_3C2D_1E0E, 0, "R1 station");
      for (int b = 0; b < 6; b++)
         frame(48'h5A4B_3C2D_1E0E ^ (48'h40 << (8*b)), 1, "R1 near miss");

      // R6 broadcast with empty table
      frame(48'hFFFF_FFFF_FFFF, 0, "R6 broadcast");

      // R4 R2 single entry
      m1 = 48'h0000_5E00_0001 | 48'h1;
      m2 = m1;
      while (hidx(m2) == hidx(m1)) m2 = next_addr() | 48'h1;
      set_entry(hidx(m1), 1'b1);
      frame(m1, 0, "R4 hash hit");
      frame(m2, 2, "R4 other index");

      // R5 unicast with enabled entry
      u = next_addr() & ~48'h1;
      set_entry(hidx(u), 1'b1);
      frame(u, 0, "R5 unicast ignored");

      // R11 priority: station over hash, broadcast over station
      set_station(m1);
      frame(m1, 0, "R11 station over hash");
      set_station(48'hFFFF_FFFF_FFFF);
      frame(48'hFFFF_FFFF_FFFF, 0, "R11 broadcast over station");
      set_station(48'h5A4B_3C2D_1E0E);

      // R2 R3 striped sweep
      for (int i = 0; i < NENT; i++) set_entry(i, (i % 3) == 0);
      for (int n = 0; n < 300; n++) begin
         a = next_addr() | 48'h1;
         frame(a, n % 3, "R2 striped sweep");
      end

      // R3 enable all, then clear single entries
      for (int i = 0; i < NENT; i++) set_entry(i, 1'b1);
      for (int n = 0; n < 20; n++) frame(next_addr() | 48'h1, 0, "R3 all enabled");
      set_entry(hidx(m1), 1'b0);
      frame(m1, 0, "R3 cleared entry");
      frame(m2, 0, "R3 neighbour kept");

      // R9 restart mid-address and stray bytes
      quiet = 1'b1;
      for (int i = 0; i < 3; i++) begin
         da_vld = 1'b1; da_sof = (i == 0); da_byte = 8'hA5;
         @(posedge clk); @(negedge clk);
         if (dec_vld) quiet = 1'b0;
      end
      da_vld = 1'b0;
      frame(m2, 0, "R9 restart");
      for (int i = 0; i < 8; i++) begin
         da_vld = 1'b1; da_sof = 1'b0; da_byte = 8'hFF;
         @(posedge clk); @(negedge clk);
         if (dec_vld) quiet = 1'b0;
      end
      da_vld = 1'b0;
      repeat (3) begin @(posedge clk); @(negedge clk); if (dec_vld) quiet = 1'b0; end
      check(quiet, "R9 no decision for partial or stray bytes", !quiet, 0);
      frame(48'h5A4B_3C2D_1E0E, 0, "R9 clean after stray");

      // R7 promiscuous
      set_prom(1'b1);
      for (int n = 0; n < 10; n++) frame(next_addr(), 1, "R7 promiscuous");
      frame(48'hFFFF_FFFF_FFFF, 0, "R7 R11 promisc over broadcast");
      frame(48'h5A4B_3C2D_1E0E, 0, "R7 R11 promisc over station");
      set_prom(1'b0);
      frame(next_addr() & ~48'h1, 0, "R7 promiscuous off");

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule